// File: doc/BRIEF.md
# DMA Channel Event and Interrupt Register Bank

This block holds the per-channel control state for a 64-channel DMA controller. For each channel it keeps a pending-event flag, an event enable, a secondary (in-service) flag and a missed-event flag. It also keeps a completion-pending flag and a completion-interrupt enable. Software reaches every flag through a simple register write and read port. Each writable flag has separate write-one-to-set and write-one-to-clear registers, so software never needs a read-modify-write.

Hardware event lines and software requests raise channel trigger pulses toward the transfer engine. Completion codes coming back from the engine set pending bits, and these drive a level completion interrupt. An event that reaches a channel already in service is dropped and recorded as missed, and missed events drive a level error interrupt. Each interrupt has an evaluate register. A write to it forces the line low for one cycle, so a still-valid condition shows a fresh rising edge.

Top module: `dmab_regbank`

## Requirements
- R1: Channel n is bit n%32 of word n/32. Register k sits at byte offset 8k, with its upper word at 8k+4. Writes whose address bits [1:0] are non-zero are ignored. Register indices: 0 event (read), 1 event clear, 2 event set, 3 enable (read), 4 enable clear, 5 enable set, 6 secondary (read), 7 secondary clear, 8 missed (read), 9 missed clear, 10 interrupt enable (read), 11 interrupt enable clear, 12 interrupt enable set, 13 pending (read), 14 pending clear, 15 completion evaluate, 16 channel stop, 17 error evaluate.
- R2: A write to a set or clear register changes only the bits written as 1. All other bits keep their value.
- R3: A hardware event on an enabled, idle channel is latched at a clock edge. The channel's trig bit is high for exactly the following cycle. At the next edge the event bit clears and the secondary bit sets.
- R4: A hardware event on a disabled channel stays in the event register without triggering. Setting the enable later triggers the channel in the cycle after that write.
- R5: Writing 1 to a channel's bit in event set triggers it in the cycle after the write, whatever its enable.
- R6: A secondary bit stays set until a 1 is written to secondary clear.
- R7: A hardware event or software set for a channel is dropped, and its missed bit is set, in two cases: the channel's secondary bit is already 1, or the channel's trig is high in that cycle. The missed bit stays until a 1 is written to missed clear.
- R8: A write of 1 to channel stop clears that channel's enable, event, secondary and missed bits. The stop takes priority over an event arriving in the same cycle.
- R9: A completion with code c (0..63) sets pending bit c at the next edge. If a pending-clear write for the same bit falls in the same cycle, the set wins.
- R10: irq_done is high while any channel has both its pending bit and its interrupt-enable bit set.
- R11: A write with bit 0 set to completion evaluate holds irq_done low for the one cycle after the write. After that, irq_done follows R10 again.
- R12: irq_err is high while any missed bit is set. A write with bit 0 set to error evaluate holds it low for the one cycle after the write.
- R13: Writing 1 to event clear discards a latched event, so a later enable does not trigger.
- R14: After reset every register reads zero and trig, irq_done and irq_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| hw_evt | input | 64 | Hardware event lines, one per channel |
| cmpl_valid | input | 1 | Completion code valid |
| cmpl_code | input | 6 | Completed channel code |
| trig | output | 64 | Per-channel trigger pulses |
| irq_done | output | 1 | Completion interrupt |
| irq_err | output | 1 | Missed-event interrupt |

## Verification
Two functions can fall in the same cycle: a channel firing its trigger, and a new event arriving for that same channel. The bench provokes this by holding a hardware event line high for two consecutive cycles. It judges the result by requiring a single trigger pulse, with the channel's missed bit and irq_err set afterwards. The same pattern is applied to completion capture against a pending-clear write on the same bit: the completion is driven in the write cycle, and the bench expects the pending bit to survive.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
  // Register indices; byte offset is index times the register stride.
  localparam int RG_EVT       = 0;
  localparam int RG_EVT_CLR   = 1;
  localparam int RG_EVT_SET   = 2;
  localparam int RG_EN        = 3;
  localparam int RG_EN_CLR    = 4;
  localparam int RG_EN_SET    = 5;
  localparam int RG_SEC       = 6;
  localparam int RG_SEC_CLR   = 7;
  localparam int RG_MISS      = 8;
  localparam int RG_MISS_CLR  = 9;
  localparam int RG_IEN       = 10;
  localparam int RG_IEN_CLR   = 11;
  localparam int RG_IEN_SET   = 12;
  localparam int RG_PEND      = 13;
  localparam int RG_PEND_CLR  = 14;
  localparam int RG_EVAL      = 15;
  localparam int RG_HALT      = 16;
  localparam int RG_EEVAL     = 17;

  typedef struct packed {
    logic evt_clr;
    logic evt_set;
    logic en_clr;
    logic en_set;
    logic sec_clr;
    logic miss_clr;
    logic ien_clr;
    logic ien_set;
    logic pend_clr;
    logic eval;
    logic err_eval;
    logic halt;
  } wr_strb_t;
endpackage

// File: rtl/dmab_decode.sv
module dmab_decode
  import dmab_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int DW     = 32,
  parameter int AW     = 8
) (
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output wr_strb_t          strb,
  output logic [NUM_CH-1:0] mask
);
  localparam int NWORD = NUM_CH / DW;
  localparam int SEL_W = (NWORD > 1) ? $clog2(NWORD) : 1;
  localparam int IDX_W = AW - 2 - SEL_W;

  logic             aligned;
  logic             wr_ok;
  logic [SEL_W-1:0] word;
  logic [IDX_W-1:0] idx;

  assign aligned = (addr[1:0] == 2'b00);
  assign wr_ok   = wr & aligned;
  assign word    = addr[2 +: SEL_W];
  assign idx     = addr[AW-1 -: IDX_W];

  for (genvar w = 0; w < NWORD; w++) begin : g_mask
    assign mask[w*DW +: DW] = (NWORD == 1 || word == SEL_W'(w)) ? wdata : '0;
  end

  always_comb begin
    strb = '0;
    if (wr_ok) begin
      case (int'(idx))
        RG_EVT_CLR:  strb.evt_clr  = 1'b1;
        RG_EVT_SET:  strb.evt_set  = 1'b1;
        RG_EN_CLR:   strb.en_clr   = 1'b1;
        RG_EN_SET:   strb.en_set   = 1'b1;
        RG_SEC_CLR:  strb.sec_clr  = 1'b1;
        RG_MISS_CLR: strb.miss_clr = 1'b1;
        RG_IEN_CLR:  strb.ien_clr  = 1'b1;
        RG_IEN_SET:  strb.ien_set  = 1'b1;
        RG_PEND_CLR: strb.pend_clr = 1'b1;
        RG_EVAL:     strb.eval     = wdata[0];
        RG_EEVAL:    strb.err_eval = wdata[0];
        RG_HALT:     strb.halt     = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/dmab_chan_cell.sv
module dmab_chan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_evt,
  input  logic sw_set,
  input  logic evt_clr,
  input  logic en_set,
  input  logic en_clr,
  input  logic sec_clr,
  input  logic miss_clr,
  input  logic halt,
  output logic trig,
  output logic ev_o,
  output logic en_o,
  output logic sec_o,
  output logic miss_o
);
  logic ev_q, man_q, en_q, sec_q, miss_q;
  logic ev_d, man_d, en_d, sec_d, miss_d;
  logic arrive, fire, drop, ce;

  assign arrive = hw_evt | sw_set;
  assign fire   = ev_q & (en_q | man_q);
  assign drop   = arrive & (sec_q | fire);
  assign ce     = halt | arrive | fire | evt_clr | en_set | en_clr | sec_clr | miss_clr;

  always_comb begin
    ev_d   = ev_q;
    man_d  = man_q;
    en_d   = en_q;
    sec_d  = sec_q;
    miss_d = miss_q;
    if (halt) begin
      ev_d   = 1'b0;
      man_d  = 1'b0;
      en_d   = 1'b0;
      sec_d  = 1'b0;
      miss_d = 1'b0;
    end else begin
      if (fire || evt_clr) begin
        ev_d  = 1'b0;
        man_d = 1'b0;
      end
      if (arrive && !drop) ev_d  = 1'b1;
      if (sw_set && !drop) man_d = 1'b1;
      if (en_set)      en_d = 1'b1;
      else if (en_clr) en_d = 1'b0;
      if (fire)         sec_d = 1'b1;
      else if (sec_clr) sec_d = 1'b0;
      if (drop)          miss_d = 1'b1;
      else if (miss_clr) miss_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= 1'b0;
      man_q  <= 1'b0;
      en_q   <= 1'b0;
      sec_q  <= 1'b0;
      miss_q <= 1'b0;
    end else if (ce) begin
      ev_q   <= ev_d;
      man_q  <= man_d;
      en_q   <= en_d;
      sec_q  <= sec_d;
      miss_q <= miss_d;
    end
  end

  assign trig   = fire;
  assign ev_o   = ev_q;
  assign en_o   = en_q;
  assign sec_o  = sec_q;
  assign miss_o = miss_q;
endmodule

// File: rtl/dmab_irq.sv
module dmab_irq #(
  parameter int NUM_CH = 64,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpl_valid,
  input  logic [CODE_W-1:0] cmpl_code,
  input  logic [NUM_CH-1:0] pend_clr,
  input  logic [NUM_CH-1:0] ien_set,
  input  logic [NUM_CH-1:0] ien_clr,
  input  logic [NUM_CH-1:0] miss,
  input  logic              eval_wr,
  input  logic              err_eval_wr,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] ien_o,
  output logic              irq_done,
  output logic              irq_err
);
  logic [NUM_CH-1:0] pend_q, pend_d, ien_q, ien_d, code_hot;
  logic              pend_ce, ien_ce;
  logic              blank_q, eblank_q;

  assign code_hot = cmpl_valid ? (NUM_CH'(1) << cmpl_code) : '0;
  assign pend_ce  = cmpl_valid | (|pend_clr);
  assign ien_ce   = (|ien_set) | (|ien_clr);

  always_comb begin
    pend_d = (pend_q & ~pend_clr) | code_hot;
    ien_d  = (ien_q | ien_set) & ~ien_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
    end else if (ien_ce) begin
      ien_q <= ien_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q  <= 1'b0;
      eblank_q <= 1'b0;
    end else begin
      blank_q  <= eval_wr;
      eblank_q <= err_eval_wr;
    end
  end

  assign irq_done = (|(pend_q & ien_q)) & ~blank_q;
  assign irq_err  = (|miss) & ~eblank_q;
  assign pend_o   = pend_q;
  assign ien_o    = ien_q;
endmodule

// File: rtl/dmab_regbank.sv
module dmab_regbank
  import dmab_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int DW     = 32,
  parameter int AW     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [AW-1:0]             reg_addr,
  input  logic [DW-1:0]             reg_wdata,
  output logic [DW-1:0]             reg_rdata,
  input  logic [NUM_CH-1:0]         hw_evt,
  input  logic                      cmpl_valid,
  input  logic [$clog2(NUM_CH)-1:0] cmpl_code,
  output logic [NUM_CH-1:0]         trig,
  output logic                      irq_done,
  output logic                      irq_err
);
  localparam int NWORD  = NUM_CH / DW;
  localparam int SEL_W  = (NWORD > 1) ? $clog2(NWORD) : 1;
  localparam int IDX_W  = AW - 2 - SEL_W;
  localparam int CODE_W = $clog2(NUM_CH);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wr_strb_t          strb;
  logic [NUM_CH-1:0] mask;

  dmab_decode #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_dec (
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .strb  (strb),
    .mask  (mask)
  );

  logic [NUM_CH-1:0] ev_q, en_q, sec_q, miss_q, pend_q, ien_q, halt_m;
  assign halt_m = mask & {NUM_CH{strb.halt}};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dmab_chan_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .hw_evt   (hw_evt[c]),
      .sw_set   (mask[c] & strb.evt_set),
      .evt_clr  (mask[c] & strb.evt_clr),
      .en_set   (mask[c] & strb.en_set),
      .en_clr   (mask[c] & strb.en_clr),
      .sec_clr  (mask[c] & strb.sec_clr),
      .miss_clr (mask[c] & strb.miss_clr),
      .halt     (halt_m[c]),
      .trig     (trig[c]),
      .ev_o     (ev_q[c]),
      .en_o     (en_q[c]),
      .sec_o    (sec_q[c]),
      .miss_o   (miss_q[c])
    );
  end

  dmab_irq #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_irq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cmpl_valid  (cmpl_valid),
    .cmpl_code   (cmpl_code),
    .pend_clr    (mask & {NUM_CH{strb.pend_clr}}),
    .ien_set     (mask & {NUM_CH{strb.ien_set}}),
    .ien_clr     (mask & {NUM_CH{strb.ien_clr}}),
    .miss        (miss_q),
    .eval_wr     (strb.eval),
    .err_eval_wr (strb.err_eval),
    .pend_o      (pend_q),
    .ien_o       (ien_q),
    .irq_done    (irq_done),
    .irq_err     (irq_err)
  );

  // Read path: write-only aliases read as zero.
  logic [IDX_W-1:0]  rd_idx;
  logic [SEL_W-1:0]  rd_word;
  logic [NUM_CH-1:0] rd_vec;
  assign rd_idx  = reg_addr[AW-1 -: IDX_W];
  assign rd_word = reg_addr[2 +: SEL_W];

  always_comb begin
    case (int'(rd_idx))
      RG_EVT:  rd_vec = ev_q;
      RG_EN:   rd_vec = en_q;
      RG_SEC:  rd_vec = sec_q;
      RG_MISS: rd_vec = miss_q;
      RG_IEN:  rd_vec = ien_q;
      RG_PEND: rd_vec = pend_q;
      default: rd_vec = '0;
    endcase
  end

  always_comb begin
    reg_rdata = rd_vec[DW-1:0];
    for (int w = 1; w < NWORD; w++) begin
      if (rd_word == SEL_W'(w)) reg_rdata = rd_vec[w*DW +: DW];
    end
  end
endmodule

// File: rtl/dmab_regbank_chk.sv
module dmab_regbank_chk #(
  parameter int NUM_CH = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_CH-1:0]         trig,
  input logic [NUM_CH-1:0]         sec,
  input logic [NUM_CH-1:0]         halt_m,
  input logic [NUM_CH-1:0]         pend,
  input logic [NUM_CH-1:0]         ien,
  input logic [NUM_CH-1:0]         miss,
  input logic                      cmpl_valid,
  input logic [$clog2(NUM_CH)-1:0] cmpl_code,
  input logic                      eval_wr,
  input logic                      irq_done,
  input logic                      irq_err
);
  // R3
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig) |=> ((trig & $past(trig)) == '0));

  // R6
  trig_sets_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig) |=> ((($past(trig) & ~$past(halt_m)) & ~sec) == '0));

  // R9
  cmpl_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |=> pend[$past(cmpl_code)]);

  // R10
  done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (|(pend & ien)));

  // R11
  eval_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_wr |=> !irq_done);

  // R12
  err_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (|miss));
endmodule

bind dmab_regbank dmab_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .trig       (trig),
  .sec        (sec_q),
  .halt_m     (halt_m),
  .pend       (pend_q),
  .ien        (ien_q),
  .miss       (miss_q),
  .cmpl_valid (cmpl_valid),
  .cmpl_code  (cmpl_code),
  .eval_wr    (strb.eval),
  .irq_done   (irq_done),
  .irq_err    (irq_err)
);

// File: tb/tb_dmab_regbank.sv
module tb_dmab_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;
  localparam int I_EVT = 0, I_EVT_CLR = 1, I_EVT_SET = 2, I_EN = 3, I_EN_CLR = 4,
                 I_EN_SET = 5, I_SEC = 6, I_SEC_CLR = 7, I_MISS = 8, I_MISS_CLR = 9,
                 I_IEN = 10, I_IEN_CLR = 11, I_IEN_SET = 12, I_PEND = 13,
                 I_PEND_CLR = 14, I_EVAL = 15, I_HALT = 16, I_EEVAL = 17;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] hw_evt;
  logic        cmpl_valid;
  logic [5:0]  cmpl_code;
  logic [63:0] trig;
  logic        irq_done, irq_err;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmab_regbank dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_evt(hw_evt),
    .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code), .trig(trig),
    .irq_done(irq_done), .irq_err(irq_err)
  );

  function automatic logic [63:0] bit64(int ch);
    return 64'(1) << ch;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, int word, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'(idx*8 + word*4); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic wr64(int idx, logic [63:0] m);
    wr(idx, 0, m[31:0]);
    wr(idx, 1, m[63:32]);
  endtask

  task automatic rd64(int idx, output logic [63:0] v);
    reg_addr = 8'(idx*8);     #1; v[31:0]  = reg_rdata;
    reg_addr = 8'(idx*8 + 4); #1; v[63:32] = reg_rdata;
  endtask

  task automatic pulse_evt(logic [63:0] m);
    @(negedge clk); hw_evt = m;
    @(negedge clk); hw_evt = '0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    hw_evt = '0; cmpl_valid = 1'b0; cmpl_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R14 reset state
    for (int i = 0; i < 18; i++) begin
      rd64(i, v);
      chk("R14 reg", v, '0);
    end
    chk("R14 trig", trig, '0);
    chk("R14 irq", {62'd0, irq_done, irq_err}, '0);

    // R1 per-channel placement and R2 bit isolation on enable
    for (int ch = 0; ch < 64; ch++) begin
      wr(I_EN_SET, ch >> 5, 32'(1) << (ch & 31));
      rd64(I_EN, v);
      chk("R1 enable placement", v, bit64(ch));
      wr(I_EN_CLR, ch >> 5, 32'(1) << (ch & 31));
    end
    wr64(I_EN_SET, '1);
    wr(I_EN_CLR, 1, 32'h0F0F_0F0F);
    rd64(I_EN, v);
    chk("R2 clear pattern", v, 64'hF0F0_F0F0_FFFF_FFFF);
    wr(I_EN_SET, 1, 32'h0000_0101);
    rd64(I_EN, v);
    chk("R2 set pattern", v, 64'hF0F0_F1F1_FFFF_FFFF);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 8'(I_EN_CLR*8 + 1); reg_wdata = '1;
    @(negedge clk); reg_wr = 1'b0;
    rd64(I_EN, v);
    chk("R1 misaligned ignored", v, 64'hF0F0_F1F1_FFFF_FFFF);
    wr64(I_EN_SET, '1);

    // R3 / R6 hardware trigger sweep over all channels
    for (int ch = 0; ch < 64; ch++) begin
      pulse_evt(bit64(ch));
      chk("R3 trig pulse", trig, bit64(ch));
      @(negedge clk);
      chk("R3 trig single", trig, '0);
      rd64(I_EVT, v);
      chk("R3 event cleared", v, '0);
      rd64(I_SEC, v);
      chk("R6 secondary set", v, bit64(ch));
      wr(I_SEC_CLR, ch >> 5, 32'(1) << (ch & 31));
      rd64(I_SEC, v);
      chk("R6 secondary clear", v, '0);
    end
    wr64(I_EN_CLR, '1);

    // R4 pending event waits for enable
    pulse_evt(bit64(5));
    chk("R4 no trig disabled", trig, '0);
    @(negedge clk);
    chk("R4 still no trig", trig, '0);
    rd64(I_EVT, v);
    chk("R4 event held", v, bit64(5));
    wr(I_EN_SET, 0, 32'(1) << 5);
    chk("R4 trig on enable", trig, bit64(5));
    @(negedge clk);
    chk("R4 trig single", trig, '0);
    wr64(I_SEC_CLR, '1);
    wr64(I_EN_CLR, '1);

    // R13 event clear discards
    pulse_evt(bit64(40));
    rd64(I_EVT, v);
    chk("R13 event held", v, bit64(40));
    wr(I_EVT_CLR, 1, 32'(1) << 8);
    rd64(I_EVT, v);
    chk("R13 event cleared", v, '0);
    wr(I_EN_SET, 1, 32'(1) << 8);
    chk("R13 no trig", trig, '0);
    @(negedge clk);
    chk("R13 no trig later", trig, '0);
    rd64(I_SEC, v);
    chk("R13 secondary idle", v, '0);
    wr64(I_EN_CLR, '1);

    // R5 software set ignores enable
    wr(I_EVT_SET, 1, 32'(1) << 1);
    chk("R5 sw trig", trig, bit64(33));
    @(negedge clk);
    chk("R5 sw trig single", trig, '0);
    rd64(I_SEC, v);
    chk("R5 secondary", v, bit64(33));
    wr64(I_SEC_CLR, '1);

    // R7 missed events; R12 error interrupt and evaluate
    wr(I_EN_SET, 0, 32'h0000_0280);
    pulse_evt(bit64(7));
    chk("R7 first trig", trig, bit64(7));
    @(negedge clk);
    pulse_evt(bit64(7));
    chk("R7 dropped no trig", trig, '0);
    rd64(I_MISS, v);
    chk("R7 missed hw", v, bit64(7));
    chk("R12 err level", {63'd0, irq_err}, 64'd1);
    wr(I_EVT_SET, 0, 32'(1) << 7);
    chk("R7 sw dropped", trig, '0);
    @(negedge clk); hw_evt = bit64(9);
    @(negedge clk);
    chk("R7 coincident first", trig, bit64(9));
    @(negedge clk); hw_evt = '0;
    chk("R7 coincident no retrig", trig, '0);
    rd64(I_MISS, v);
    chk("R7 missed coincident", v, bit64(7) | bit64(9));
    wr(I_EEVAL, 0, 32'd1);
    chk("R12 err blank", {63'd0, irq_err}, 64'd0);
    @(negedge clk);
    chk("R12 err returns", {63'd0, irq_err}, 64'd1);
    wr(I_MISS_CLR, 0, 32'(1) << 7);
    rd64(I_MISS, v);
    chk("R7 missed clear one", v, bit64(9));
    wr(I_MISS_CLR, 0, 32'(1) << 9);
    chk("R12 err low", {63'd0, irq_err}, 64'd0);
    wr64(I_SEC_CLR, '1);
    wr64(I_EN_CLR, '1);

    // R9 / R10 completion sweep
    wr64(I_IEN_SET, '1);
    for (int c = 0; c < 64; c++) begin
      @(negedge clk); cmpl_valid = 1'b1; cmpl_code = 6'(c);
      @(negedge clk); cmpl_valid = 1'b0;
      rd64(I_PEND, v);
      chk("R9 pending set", v, bit64(c));
      chk("R10 irq high", {63'd0, irq_done}, 64'd1);
      wr(I_PEND_CLR, c >> 5, 32'(1) << (c & 31));
      chk("R10 irq low", {63'd0, irq_done}, 64'd0);
    end
    @(negedge clk); cmpl_valid = 1'b1; cmpl_code = 6'd12;
    @(negedge clk); cmpl_valid = 1'b1; cmpl_code = 6'd12;
    reg_wr = 1'b1; reg_addr = 8'(I_PEND_CLR*8); reg_wdata = 32'(1) << 12;
    @(negedge clk); cmpl_valid = 1'b0; reg_wr = 1'b0;
    rd64(I_PEND, v);
    chk("R9 set beats clear", v, bit64(12));
    wr(I_IEN_CLR, 0, 32'(1) << 12);
    chk("R10 masked", {63'd0, irq_done}, 64'd0);
    wr(I_IEN_SET, 0, 32'(1) << 12);
    chk("R10 unmasked", {63'd0, irq_done}, 64'd1);

    // R11 evaluate re-pulse
    wr(I_EVAL, 0, 32'd1);
    chk("R11 blank", {63'd0, irq_done}, 64'd0);
    @(negedge clk);
    chk("R11 returns", {63'd0, irq_done}, 64'd1);
    wr(I_PEND_CLR, 0, 32'(1) << 12);
    wr(I_EVAL, 0, 32'd1);
    @(negedge clk);
    chk("R11 nothing pending", {63'd0, irq_done}, 64'd0);

    // R8 stop
    wr(I_EN_SET, 0, 32'(1) << 3);
    pulse_evt(bit64(3));
    @(negedge clk);
    pulse_evt(bit64(3));
    pulse_evt(bit64(4));
    rd64(I_EVT, v);  chk("R8 setup event", v, bit64(4));
    rd64(I_MISS, v); chk("R8 setup missed", v, bit64(3));
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'(I_HALT*8); reg_wdata = 32'h18; hw_evt = bit64(4);
    @(negedge clk); reg_wr = 1'b0; hw_evt = '0;
    rd64(I_EN, v);   chk("R8 enable cleared", v, '0);
    rd64(I_EVT, v);  chk("R8 event cleared", v, '0);
    rd64(I_SEC, v);  chk("R8 secondary cleared", v, '0);
    rd64(I_MISS, v); chk("R8 missed cleared", v, '0);
    chk("R8 no trig", trig, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule